// File: doc/BRIEF.md
# Memory dependence wakeup unit

This block tracks the memory operations in flight in an out-of-order core and decides when each one may issue. It keeps a small table of loads, stores and barriers. Each entry records the operation's sequence number, thread, kind, whether its source registers are ready and whether its memory dependence has been resolved. When both conditions hold, the operation's sequence number goes out on a ready stream to the issue logic.

Dependences come from two places. The first is an active barrier: a full barrier holds back younger loads and stores, and a write barrier holds back younger stores. The second is the producer sequence number that an external store-set predictor supplies alongside a speculative insert. A dependent operation waits until its producer store or barrier completes. Squash, reschedule/replay and non-speculative handling are driven by plain command inputs. One command is accepted per clock.

The ready output is a valid/ready stream. While `rdy_valid` is high and `rdy_ready` is low, `rdy_seq` holds its value. Wakeups that cannot enter the output FIFO stay pending in the table and are not lost. When several operations become ready in the same cycle, they leave oldest first, meaning the lowest sequence number first.

Top module: `mdw_unit`

## Requirements
- R1: On speculative insert (op 1), a load (kind 0) depends on the last full barrier (kind 2) while one is active, and a store (kind 1) depends on the last full or write barrier (kind 3) while one is active; a write barrier never holds a load.
- R2: With no active barrier, the producer is `pred_seq`. A producer of zero, or one whose sequence number is not in the table, means no dependence.
- R3: An operation with no dependence and `cmd_regs_rdy` high at insert is emitted on the ready stream without further commands.
- R4: An operation inserted with a dependence is not emitted. `conf_ld_cnt` rises by one for a load and `conf_st_cnt` by one for a store.
- R5: A register-ready command (op 4) emits the matching entry only if its memory dependence is already resolved.
- R6: Completion (op 8) of a store or barrier resolves every entry depending on it. Those with ready registers are emitted; the rest only become resolved. Completion of a load resolves nothing. Completion removes the entry.
- R7: Barrier insert (op 3) records the barrier's sequence number per barrier class. Completing a barrier clears a class only when the recorded number equals the completing number.
- R8: A non-speculative insert (op 2) makes no dependence check. Its entry is emitted only by a non-speculative-ready command (op 5), never by op 4.
- R9: Squash (op 9) removes every entry of `cmd_tid` whose sequence number exceeds `cmd_seq`, including any pending emission or replay mark. Other threads are untouched.
- R10: Reschedule (op 6) marks an entry for replay. Replay (op 7) emits all marked entries.
- R11: `full` is high when all table entries are occupied. An insert (ops 1 to 3) while full is ignored.
- R12: Ready-stream data holds while stalled. Operations woken together leave in ascending sequence order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one per cycle |
| cmd_op | input | 4 | Command code (0 none, 1 insert, 2 insert non-speculative, 3 insert barrier, 4 registers ready, 5 non-speculative ready, 6 reschedule, 7 replay, 8 complete, 9 squash) |
| cmd_kind | input | 2 | Operation kind: 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_seq | input | SEQ_W | Sequence number of the operation, or squash boundary |
| cmd_tid | input | TID_W | Thread of the operation or squash |
| cmd_regs_rdy | input | 1 | Source registers ready at insert |
| pred_seq | input | SEQ_W | Predictor's producer store sequence number, 0 for none |
| rdy_valid | output | 1 | Ready stream valid |
| rdy_ready | input | 1 | Ready stream accept |
| rdy_seq | output | SEQ_W | Sequence number of the operation allowed to issue |
| conf_ld_cnt | output | CNT_W | Loads inserted with a dependence |
| conf_st_cnt | output | CNT_W | Stores inserted with a dependence |
| full | output | 1 | No free table entry |

## Verification
Two functions can meet in the same cycle: a squash, and an emission of a victim of that squash that is still waiting in the table. A squash of an entry already inside the output FIFO is not among them. The squash must win. The bench provokes this by stalling the ready stream, so that some emissions sit in the FIFO and the rest stay pending in the table, and then squashing part of the pending set. After the stall is released, the stream is judged against the arithmetically expected survivors: everything already in the FIFO plus the unsquashed pending entries, in ascending order. A sweep over barrier class, operation kind, register readiness and predictor answer separately checks the emission point and the conflict counters for every combination.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_INS     = 4'd1,
    OP_INS_NS  = 4'd2,
    OP_INS_BAR = 4'd3,
    OP_REGS    = 4'd4,
    OP_NS_RDY  = 4'd5,
    OP_RESCHED = 4'd6,
    OP_REPLAY  = 4'd7,
    OP_DONE    = 4'd8,
    OP_SQUASH  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_MBAR  = 2'd2,
    K_WBAR  = 2'd3
  } kind_e;
endpackage

// File: rtl/mdw_free_find.sv
module mdw_free_find #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mdw_oldest.sv
module mdw_oldest #(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  logic [SEQ_W-1:0] seqs [N],
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [SEQ_W-1:0] best;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || seqs[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = seqs[i];
      end
    end
  end
endmodule

// File: rtl/mdw_ready_fifo.sv
module mdw_ready_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         can_push,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign can_push  = (count != CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && can_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      end
      if (pop)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(push && can_push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/mdw_unit.sv
module mdw_unit
  import mdw_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 1,
  parameter int CNT_W      = 8,
  parameter int FIFO_DEPTH = 2,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [1:0]       cmd_kind,
  input  logic [SEQ_W-1:0] cmd_seq,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic             cmd_regs_rdy,
  input  logic [SEQ_W-1:0] pred_seq,
  output logic             rdy_valid,
  input  logic             rdy_ready,
  output logic [SEQ_W-1:0] rdy_seq,
  output logic [CNT_W-1:0] conf_ld_cnt,
  output logic [CNT_W-1:0] conf_st_cnt,
  output logic             full
);
  // entry state
  logic [ENTRIES-1:0] e_vld, e_regs, e_mdr, e_dep, e_pend, e_rply;
  logic [SEQ_W-1:0]   e_seq  [ENTRIES];
  logic [SEQ_W-1:0]   e_prod [ENTRIES];
  logic [TID_W-1:0]   e_tid  [ENTRIES];
  kind_e              e_kind [ENTRIES];

  // barrier state, one per class
  logic             lb_on, sb_on;
  logic [SEQ_W-1:0] lb_seq, sb_seq;

  op_e   op;
  kind_e ckind;
  assign op    = op_e'(cmd_op);
  assign ckind = kind_e'(cmd_kind);

  logic is_ins, is_ins_any, is_done, is_sq;
  assign is_ins     = cmd_valid && (op == OP_INS);
  assign is_ins_any = cmd_valid && (op == OP_INS || op == OP_INS_NS || op == OP_INS_BAR);
  assign is_done    = cmd_valid && (op == OP_DONE);
  assign is_sq      = cmd_valid && (op == OP_SQUASH);

  // free slot
  logic             alloc_ok;
  logic [IDX_W-1:0] alloc_idx;
  mdw_free_find #(.N(ENTRIES)) u_free (.busy(e_vld), .found(alloc_ok), .idx(alloc_idx));
  assign full = !alloc_ok;

  // producer choice and lookups
  logic [SEQ_W-1:0]   chosen_prod;
  logic               prod_present, has_dep;
  logic [ENTRIES-1:0] hit, kill, wake;
  logic               done_wakes;
  kind_e              done_kind;

  always_comb begin
    if (ckind == K_LOAD && lb_on)       chosen_prod = lb_seq;
    else if (ckind != K_LOAD && sb_on)  chosen_prod = sb_seq;
    else                                chosen_prod = pred_seq;
  end

  always_comb begin
    prod_present = 1'b0;
    done_wakes   = 1'b0;
    done_kind    = K_LOAD;
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i]  = e_vld[i] && (e_seq[i] == cmd_seq);
      kill[i] = is_sq && e_vld[i] && (e_tid[i] == cmd_tid) && (e_seq[i] > cmd_seq);
      if (e_vld[i] && e_seq[i] == chosen_prod) prod_present = 1'b1;
      if (hit[i]) begin
        done_kind = e_kind[i];
        if (e_kind[i] != K_LOAD) done_wakes = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++)
      wake[i] = is_done && done_wakes && e_vld[i] && e_dep[i] && (e_prod[i] == cmd_seq);
  end
  assign has_dep = (chosen_prod != '0) && prod_present;

  // oldest pending emission into the output FIFO
  logic [ENTRIES-1:0] cand;
  logic               pick_ok, can_push, push;
  logic [IDX_W-1:0]   pick_idx;
  assign cand = e_pend & e_vld & ~kill & ~(is_done ? hit : '0);
  mdw_oldest #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_pick (
    .cand(cand), .seqs(e_seq), .found(pick_ok), .idx(pick_idx));
  assign push = pick_ok && can_push;

  mdw_ready_fifo #(.DEPTH(FIFO_DEPTH), .W(SEQ_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(e_seq[pick_idx]),
    .can_push(can_push), .out_valid(rdy_valid), .out_ready(rdy_ready),
    .out_data(rdy_seq));

  // table update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_regs <= '0;
      e_mdr  <= '0;
      e_dep  <= '0;
      e_pend <= '0;
      e_rply <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (push && pick_idx == IDX_W'(i)) e_pend[i] <= 1'b0;
        if (is_ins_any && alloc_ok && alloc_idx == IDX_W'(i)) begin
          e_vld[i]  <= 1'b1;
          e_seq[i]  <= cmd_seq;
          e_tid[i]  <= cmd_tid;
          e_kind[i] <= ckind;
          e_prod[i] <= chosen_prod;
          e_regs[i] <= cmd_regs_rdy;
          e_rply[i] <= 1'b0;
          e_dep[i]  <= is_ins && has_dep;
          e_mdr[i]  <= is_ins && !has_dep;
          e_pend[i] <= is_ins && !has_dep && cmd_regs_rdy;
        end
        if (cmd_valid && hit[i]) begin
          case (op)
            OP_REGS: begin
              e_regs[i] <= 1'b1;
              if (e_mdr[i]) e_pend[i] <= 1'b1;
            end
            OP_NS_RDY:  e_pend[i] <= 1'b1;
            OP_RESCHED: e_rply[i] <= 1'b1;
            OP_DONE: begin
              e_vld[i]  <= 1'b0;
              e_pend[i] <= 1'b0;
              e_rply[i] <= 1'b0;
            end
            default: ;
          endcase
        end
        if (cmd_valid && op == OP_REPLAY && e_rply[i]) begin
          e_rply[i] <= 1'b0;
          e_pend[i] <= 1'b1;
        end
        if (wake[i]) begin
          e_mdr[i] <= 1'b1;
          e_dep[i] <= 1'b0;
          if (e_regs[i]) e_pend[i] <= 1'b1;
        end
        if (kill[i]) begin
          e_vld[i]  <= 1'b0;
          e_pend[i] <= 1'b0;
          e_rply[i] <= 1'b0;
        end
      end
    end
  end

  // barriers and conflict counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lb_on       <= 1'b0;
      sb_on       <= 1'b0;
      lb_seq      <= '0;
      sb_seq      <= '0;
      conf_ld_cnt <= '0;
      conf_st_cnt <= '0;
    end else begin
      if (cmd_valid && op == OP_INS_BAR && alloc_ok) begin
        if (ckind == K_MBAR) begin
          lb_on  <= 1'b1;
          lb_seq <= cmd_seq;
        end
        if (ckind == K_MBAR || ckind == K_WBAR) begin
          sb_on  <= 1'b1;
          sb_seq <= cmd_seq;
        end
      end
      if (is_done && (done_kind == K_MBAR || done_kind == K_WBAR)) begin
        if (done_kind == K_MBAR && lb_on && lb_seq == cmd_seq) lb_on <= 1'b0;
        if (sb_on && sb_seq == cmd_seq) sb_on <= 1'b0;
      end
      if (is_ins && alloc_ok && has_dep) begin
        if (ckind == K_LOAD) conf_ld_cnt <= conf_ld_cnt + CNT_W'(1);
        else                 conf_st_cnt <= conf_st_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdw_unit_chk.sv
module mdw_unit_chk #(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [3:0]         cmd_op,
  input logic               rdy_valid,
  input logic               rdy_ready,
  input logic [SEQ_W-1:0]   rdy_seq,
  input logic [CNT_W-1:0]   conf_ld_cnt,
  input logic [CNT_W-1:0]   conf_st_cnt,
  input logic               full,
  input logic [ENTRIES-1:0] e_vld
);
  // R12
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_valid && !rdy_ready |=> rdy_valid && $stable(rdy_seq));

  // R4
  ld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf_ld_cnt != $past(conf_ld_cnt) |->
      conf_ld_cnt == $past(conf_ld_cnt) + CNT_W'(1) && $past(cmd_valid) && $past(cmd_op) == 4'd1);

  // R4
  st_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf_st_cnt != $past(conf_st_cnt) |->
      conf_st_cnt == $past(conf_st_cnt) + CNT_W'(1) && $past(cmd_valid) && $past(cmd_op) == 4'd1);

  // R11
  full_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && cmd_valid && (cmd_op == 4'd1 || cmd_op == 4'd2 || cmd_op == 4'd3) |=> e_vld == $past(e_vld));
endmodule

bind mdw_unit mdw_unit_chk #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_seq(rdy_seq),
  .conf_ld_cnt(conf_ld_cnt), .conf_st_cnt(conf_st_cnt), .full(full), .e_vld(e_vld));

// File: tb/mdw_unit_tb.sv
module mdw_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [15:0] cmd_seq = '0;
  logic [0:0]  cmd_tid = '0;
  logic        cmd_regs_rdy = 1'b0;
  logic [15:0] pred_seq = '0;
  logic        rdy_valid;
  logic        rdy_ready = 1'b1;
  logic [15:0] rdy_seq;
  logic [7:0]  conf_ld_cnt, conf_st_cnt;
  logic        full;

  always #2 clk = ~clk;

  mdw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_kind(cmd_kind), .cmd_seq(cmd_seq), .cmd_tid(cmd_tid),
    .cmd_regs_rdy(cmd_regs_rdy), .pred_seq(pred_seq), .rdy_valid(rdy_valid),
    .rdy_ready(rdy_ready), .rdy_seq(rdy_seq), .conf_ld_cnt(conf_ld_cnt),
    .conf_st_cnt(conf_st_cnt), .full(full));

  int nchk = 0, nfail = 0, ngot = 0, exp_ld = 0, exp_st = 0, base = 0;
  int got [0:1023];

  always @(posedge clk)
    if (rst_n && rdy_valid && rdy_ready) begin
      got[ngot % 1024] = int'(rdy_seq);
      ngot++;
    end

  task automatic issue(input int op, input int kind, input int seq, input int tid,
                       input bit regs, input int pred);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[3:0]; cmd_kind = kind[1:0]; cmd_seq = seq[15:0];
    cmd_tid = tid[0:0]; cmd_regs_rdy = regs; pred_seq = pred[15:0];
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare emissions since 'base' with an expected count and last sequence number
  task automatic expect_out(input string req, input int n, input int last);
    chk(ngot - base == n, req, ngot - base, n);
    if (n > 0 && ngot > 0) chk(got[(ngot - 1) % 1024] == last, req, got[(ngot - 1) % 1024], last);
    base = ngot;
  endtask

  task automatic counters(input string req);
    chk(int'(conf_ld_cnt) == exp_ld, {req, " load count"}, int'(conf_ld_cnt), exp_ld);
    chk(int'(conf_st_cnt) == exp_st, {req, " store count"}, int'(conf_st_cnt), exp_st);
  endtask

  task automatic clear_all();
    issue(9, 0, 0, 0, 0, 0);
    issue(9, 0, 0, 1, 0, 0);
    settle();
    base = ngot;
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(full == 1'b0, "R11 reset full", int'(full), 0);
    chk(rdy_valid == 1'b0, "R12 reset valid", int'(rdy_valid), 0);
    counters("R4 reset");

    // sweep: barrier class x kind x regs at insert x predictor answer (R1 R2 R3 R4 R5 R6)
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 2; k++)
        for (int r = 0; r < 2; r++)
          for (int pc = 0; pc < 3; pc++) begin
            bit blocked, dep;
            int pred;
            pred = (pc == 0) ? 0 : (pc == 1) ? 20 : 25;
            blocked = (b == 1) || (b == 2 && k == 1);
            dep = blocked || (pc == 1);
            if (b != 0) issue(3, (b == 1) ? 2 : 3, 10, 0, 0, 0);
            issue(2, 1, 20, 0, 0, 0);
            settle(); base = ngot;
            issue(1, k, 30, 0, r[0], pred);
            settle();
            if (dep) begin
              if (k == 0) exp_ld++; else exp_st++;
            end
            expect_out(dep ? "R1 R2 R4 held" : "R3 immediate", (!dep && r == 1) ? 1 : 0, 30);
            counters("R4 sweep");
            if (r == 0) begin
              issue(4, 0, 30, 0, 0, 0);
              settle();
              expect_out("R5 regs event", dep ? 0 : 1, 30);
            end
            if (dep) begin
              issue(8, 0, blocked ? 10 : 20, 0, 0, 0);
              settle();
              expect_out("R6 wake on producer", 1, 30);
            end
            issue(8, 0, 30, 0, 0, 0);
            issue(8, 0, 20, 0, 0, 0);
            if (b != 0) issue(8, 0, 10, 0, 0, 0);
            settle();
            expect_out("R6 cleanup", 0, 0);
          end

    // R6: wake with registers not ready only resolves; load completion wakes nothing
    issue(2, 1, 40, 0, 0, 0);
    issue(1, 0, 41, 0, 0, 40);
    exp_ld++;
    issue(8, 0, 40, 0, 0, 0);
    settle();
    expect_out("R6 resolve without regs", 0, 0);
    issue(4, 0, 41, 0, 0, 0);
    settle();
    expect_out("R6 regs after wake", 1, 41);
    issue(2, 0, 42, 0, 0, 0);
    issue(1, 0, 43, 0, 1, 42);
    exp_ld++;
    issue(8, 0, 42, 0, 0, 0);
    settle();
    expect_out("R6 load completion no wake", 0, 0);
    counters("R6");
    clear_all();

    // R7: older barrier completion leaves younger barrier's block in place
    issue(3, 2, 5, 0, 0, 0);
    issue(3, 2, 7, 0, 0, 0);
    issue(8, 0, 5, 0, 0, 0);
    issue(1, 0, 9, 0, 1, 0);
    exp_ld++;
    settle();
    expect_out("R7 younger barrier holds", 0, 0);
    counters("R7");
    issue(8, 0, 7, 0, 0, 0);
    settle();
    expect_out("R7 release on match", 1, 9);
    issue(1, 1, 12, 0, 1, 0);
    settle();
    expect_out("R7 store free after release", 1, 12);
    clear_all();

    // R8: non-speculative entry emitted only on its own event
    issue(2, 0, 50, 0, 1, 0);
    issue(4, 0, 50, 0, 0, 0);
    settle();
    expect_out("R8 regs event ignored", 0, 0);
    issue(5, 0, 50, 0, 0, 0);
    settle();
    expect_out("R8 nonspec ready", 1, 50);
    clear_all();

    // R10 R12: replay in age order although slots and reschedule order differ
    issue(2, 0, 63, 0, 0, 0);
    issue(2, 0, 62, 0, 0, 0);
    issue(2, 0, 61, 0, 0, 0);
    issue(6, 0, 63, 0, 0, 0);
    issue(6, 0, 61, 0, 0, 0);
    issue(6, 0, 62, 0, 0, 0);
    settle();
    expect_out("R10 reschedule alone", 0, 0);
    issue(7, 0, 0, 0, 0, 0);
    settle();
    chk(ngot - base == 3, "R10 replay count", ngot - base, 3);
    for (int i = 0; i < 3; i++)
      chk(got[(base + i) % 1024] == 61 + i, "R12 age order", got[(base + i) % 1024], 61 + i);
    base = ngot;
    // R9 R10: squash drops replay marks
    issue(6, 0, 61, 0, 0, 0);
    issue(6, 0, 62, 0, 0, 0);
    issue(6, 0, 63, 0, 0, 0);
    issue(9, 0, 61, 0, 0, 0);
    issue(7, 0, 0, 0, 0, 0);
    settle();
    expect_out("R9 replay filtered", 1, 61);
    clear_all();

    // R9: squash by thread and boundary
    for (int s = 200; s < 204; s++) issue(2, 0, s, 0, 0, 0);
    issue(2, 0, 204, 1, 0, 0);
    issue(9, 0, 201, 0, 0, 0);
    issue(5, 0, 202, 0, 0, 0);
    issue(5, 0, 203, 0, 0, 0);
    settle();
    expect_out("R9 younger removed", 0, 0);
    issue(5, 0, 201, 0, 0, 0);
    settle();
    expect_out("R9 boundary kept", 1, 201);
    issue(5, 0, 204, 1, 0, 0);
    settle();
    expect_out("R9 other thread kept", 1, 204);
    clear_all();

    // R9 R12: squash against pending emissions under back-pressure
    @(negedge clk); rdy_ready = 1'b0;
    for (int s = 301; s < 306; s++) issue(2, 0, s, 1, 0, 0);
    for (int s = 301; s < 306; s++) issue(5, 0, s, 1, 0, 0);
    settle();
    chk(ngot - base == 0, "R12 stalled", ngot - base, 0);
    chk(rdy_valid == 1'b1 && rdy_seq == 16'd301, "R12 head held", int'(rdy_seq), 301);
    issue(9, 0, 303, 1, 0, 0);
    @(negedge clk); rdy_ready = 1'b1;
    settle();
    chk(ngot - base == 3, "R9 survivors", ngot - base, 3);
    for (int i = 0; i < 3; i++)
      chk(got[(base + i) % 1024] == 301 + i, "R9 survivor order", got[(base + i) % 1024], 301 + i);
    base = ngot;
    clear_all();

    // R11: full flag and ignored insert
    for (int s = 100; s < 116; s++) begin
      chk(full == 1'b0, "R11 not full", int'(full), 0);
      issue(2, 1, s, 0, 0, 0);
    end
    @(negedge clk);
    chk(full == 1'b1, "R11 full", int'(full), 1);
    issue(1, 0, 117, 0, 1, 0);
    settle();
    expect_out("R11 insert while full ignored", 0, 0);
    issue(8, 0, 100, 0, 0, 0);
    @(negedge clk);
    chk(full == 1'b0, "R11 freed", int'(full), 0);
    issue(4, 0, 117, 0, 0, 0);
    settle();
    expect_out("R11 dropped op absent", 0, 0);
    clear_all();
    counters("R4 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule